// File: doc/BRIEF.md
# DMA Channel Register File

This block keeps the per-channel programming state of a four-channel DMA controller. For each channel it holds a 16-bit starting address, a 16-bit transfer count and two page bytes. The host reaches these through a byte-wide port. Every 16-bit value moves one byte at a time, and a single byte-pointer flip-flop, shared by every channel, chooses the byte. From each channel's page bytes and current address the block builds the physical address that the transfer engine drives onto memory.

The transfer engine reports how far it has got on a channel through a valid-qualified progress port. Host readback is live: an address read returns the current address moved by the progress, and a count read returns the programmed count minus the progress. Writing the high byte of either 16-bit register restarts the channel. This copies the programmed address into the working address and sets the progress to zero. The parameter `SHIFT` selects the build. With `SHIFT`=0 the block is a byte controller. With `SHIFT`=1 it is a word controller: its register offsets step by two and its working addresses are doubled.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel register index is `reg_off[SHIFT+3:SHIFT]`. Index bit 0 selects the count register (1) or the address register (0), and index bits 3:1 select the channel. Read data appears on `rdata` in the cycle after the read strobe and holds until the next read.
- R2: All channels share one byte-pointer flip-flop, which starts at 0. Every valid channel register read or write inverts it. While it is 0 an access reaches bits 7:0 of the 16-bit value; while it is 1 the access reaches bits 15:8.
- R3: A high-byte write to either register of a channel loads the working address with the programmed address shifted left by `SHIFT` (using the newly written byte) and sets the channel's progress to zero. A low-byte write changes neither the working address nor the progress.
- R4: A count read returns one byte of ((programmed count << `SHIFT`) − progress) >> `SHIFT`, taken modulo 2^(16+`SHIFT`) before the shift.
- R5: An address read returns one byte of (working address + progress) >> `SHIFT`. When the channel's `mode_dec` bit is 1, the sum is replaced by the difference (working address − progress).
- R6: A channel access whose index bits 3:1 are `NUM_CH` or more changes no register, leaves the flip-flop unchanged, and a read of it returns 0.
- R7: Page offsets 7, 3, 1 and 2 address channels 0, 1, 2 and 3; `pg_hi`=1 selects the high page byte. A write to any other page offset is ignored and a read of it returns 0. Page reads are registered like channel reads. A channel read in the same cycle takes priority over a page read.
- R8: The physical address of channel n sits at `phys_addr[31n+30:31n]` and equals {high page bits 6:0, page byte, 16 zero bits} OR the working address.
- R9: A `ff_clr` pulse sets the flip-flop to 0 after any access made in the same cycle. Reset clears the flip-flop, every register and `rdata`.
- R10: A progress update (`upd_vld`, `upd_ch`, `upd_cnt`) replaces the channel's progress and does not change the flip-flop. A high-byte write to the same channel in the same cycle wins, and the progress becomes 0.
- R11: With `SHIFT`=1 the register offsets step by two, and the working address and the count are formed one bit wider, as described in R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_off | input | 4+SHIFT | Channel register offset |
| ch_wr | input | 1 | Channel register write strobe |
| ch_rd | input | 1 | Channel register read strobe |
| pg_off | input | 3 | Page register offset |
| pg_hi | input | 1 | Selects the high page byte |
| pg_wr | input | 1 | Page write strobe |
| pg_rd | input | 1 | Page read strobe |
| wdata | input | 8 | Write data byte |
| ff_clr | input | 1 | Clears the byte-pointer flip-flop |
| mode_dec | input | NUM_CH | Per-channel address decrement mode |
| upd_vld | input | 1 | Progress update valid |
| upd_ch | input | log2(NUM_CH) | Channel of the progress update |
| upd_cnt | input | 16+SHIFT | New transferred count |
| rdata | output | 8 | Read data byte |
| phys_addr | output | 31*NUM_CH | Physical address of each channel |

## Verification
When the shared flip-flop goes out of step, every later channel read returns the wrong byte half. This shows on `rdata` one cycle after the first read that follows the fault, and it persists until `ff_clr` runs. When the reload or the progress state is wrong, the value appears on `phys_addr` in the cycle after the write, and on the readback as soon as a channel is read with a non-zero progress. When a page offset is decoded wrongly, a different channel's `phys_addr` field changes one cycle after the page write. The bench therefore places byte reads right after writes, updates and clears, and compares all four physical addresses after every page write.

// File: rtl/dmar_pkg.sv
// Shared constants and page-offset decoding for the DMA channel register file.
// Assumes at most eight channels, as the 3-bit channel field allows.
package dmar_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;
    localparam int PHYS_W = 31;

    typedef struct packed {
        logic       ok;
        logic [2:0] ch;
    } page_slot_t;

    // Decodes a page port offset into the channel it addresses.
    function automatic page_slot_t page_slot(input logic [2:0] off);
        page_slot_t s;
        case (off)
            3'd7:    s = '{ok: 1'b1, ch: 3'd0};
            3'd3:    s = '{ok: 1'b1, ch: 3'd1};
            3'd1:    s = '{ok: 1'b1, ch: 3'd2};
            3'd2:    s = '{ok: 1'b1, ch: 3'd3};
            default: s = '{ok: 1'b0, ch: 3'd0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dmar_chan.sv
// One DMA channel: the programmed address and count, the working address and
// the progress reported by the transfer engine. Produces the live readback values.
// Assumes the caller qualifies wr_en with a decoded channel hit and wr_hi with the shared flip-flop.
module dmar_chan
    import dmar_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_cnt,
    input  logic                     wr_hi,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     upd_en,
    input  logic [REG_W+SHIFT-1:0]   upd_cnt,
    input  logic                     dec,
    output logic [REG_W-1:0]         addr_rv,
    output logic [REG_W-1:0]         cnt_rv,
    output logic [REG_W+SHIFT-1:0]   cur_addr
);
    localparam int VAL_W = REG_W + SHIFT;

    logic [REG_W-1:0] base_addr_q, base_cnt_q, next_base_addr;
    logic [VAL_W-1:0] cur_q, prog_q, addr_val, cnt_val;

    // Programmed address seen by a reload, including a high byte written in the same cycle.
    always_comb begin
        next_base_addr = base_addr_q;
        if (wr_en && wr_hi && !wr_cnt) next_base_addr = {wdata, base_addr_q[7:0]};
    end

    // Byte-wise loading of the programmed address and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
        end else if (wr_en) begin
            if (wr_cnt) begin
                if (wr_hi) base_cnt_q[15:8] <= wdata;
                else       base_cnt_q[7:0]  <= wdata;
            end else begin
                if (wr_hi) base_addr_q[15:8] <= wdata;
                else       base_addr_q[7:0]  <= wdata;
            end
        end
    end

    // Working address and progress: a high-byte write reloads; otherwise the engine updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prog_q <= '0;
        end else if (wr_en && wr_hi) begin
            cur_q  <= VAL_W'(next_base_addr) << SHIFT;
            prog_q <= '0;
        end else if (upd_en) begin
            prog_q <= upd_cnt;
        end
    end

    // Live readback values, scaled back to register units.
    always_comb begin
        addr_val = dec ? (cur_q - prog_q) : (cur_q + prog_q);
        cnt_val  = (VAL_W'(base_cnt_q) << SHIFT) - prog_q;
        addr_rv  = REG_W'(addr_val >> SHIFT);
        cnt_rv   = REG_W'(cnt_val >> SHIFT);
        cur_addr = cur_q;
    end

    // R3: a low-byte write disturbs neither the working address nor the progress.
    a_r3_low_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && !upd_en) |=> ($stable(cur_q) && $stable(prog_q)));

    // R3: after a high-byte write the count readback equals the scaled programmed count.
    a_r3_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> (cnt_rv == base_cnt_q));

endmodule

// File: rtl/dmar_page.sv
// Page and high-page bytes for every channel, reached through a sparse port map.
// Assumes the page map of dmar_pkg; offsets that do not decode are ignored.
module dmar_page
    import dmar_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pg_wr,
    input  logic                           pg_hi,
    input  logic [2:0]                     pg_off,
    input  logic [BYTE_W-1:0]              wdata,
    output logic                           slot_ok,
    output logic [BYTE_W-1:0]              rd_byte,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  page_q,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  pageh_q
);
    localparam int CH_W = $clog2(NUM_CH);

    page_slot_t slot;

    // Decode the offset and pick the byte for a page read.
    always_comb begin
        slot    = page_slot(pg_off);
        slot_ok = slot.ok && (int'(slot.ch) < NUM_CH);
        rd_byte = '0;
        if (slot_ok) rd_byte = pg_hi ? pageh_q[slot.ch[CH_W-1:0]] : page_q[slot.ch[CH_W-1:0]];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pg
        // Store the written page byte of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_q[i]  <= '0;
                pageh_q[i] <= '0;
            end else if (pg_wr && slot_ok && slot.ch == 3'(i)) begin
                if (pg_hi) pageh_q[i] <= wdata;
                else       page_q[i]  <= wdata;
            end
        end
    end

    // R7: a write to an offset outside the map leaves every page byte unchanged.
    a_r7_bad_offset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_wr && !slot_ok) |=> ($stable(page_q) && $stable(pageh_q)));

endmodule

// File: rtl/dma_chan_regs.sv
// DMA channel register file: per-channel address, count and page state behind a
// byte port with one shared byte-pointer flip-flop, plus the physical addresses.
// Assumes NUM_CH is between 2 and 8 and SHIFT is 0 (byte build) or 1 (word build).
module dma_chan_regs
    import dmar_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SHIFT  = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [4+SHIFT-1:0]          reg_off,
    input  logic                        ch_wr,
    input  logic                        ch_rd,
    input  logic [2:0]                  pg_off,
    input  logic                        pg_hi,
    input  logic                        pg_wr,
    input  logic                        pg_rd,
    input  logic [7:0]                  wdata,
    input  logic                        ff_clr,
    input  logic [NUM_CH-1:0]           mode_dec,
    input  logic                        upd_vld,
    input  logic [$clog2(NUM_CH)-1:0]   upd_ch,
    input  logic [16+SHIFT-1:0]         upd_cnt,
    output logic [7:0]                  rdata,
    output logic [NUM_CH*PHYS_W-1:0]    phys_addr
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int VAL_W = REG_W + SHIFT;

    logic [3:0]      idx;
    logic [2:0]      chan_f;
    logic [CH_W-1:0] ch_sel;
    logic            idx_ok, acc, ff_q;
    logic [REG_W-1:0] sel_val;
    logic [BYTE_W-1:0] ch_byte, pg_byte;
    logic            pg_ok;

    logic [NUM_CH-1:0][REG_W-1:0] addr_rv, cnt_rv;
    logic [NUM_CH-1:0][VAL_W-1:0] cur_w;
    logic [NUM_CH-1:0][BYTE_W-1:0] page_q, pageh_q;

    // Register index decode and byte selection for channel reads.
    always_comb begin
        idx     = reg_off[SHIFT +: 4];
        chan_f  = idx[3:1];
        idx_ok  = int'(chan_f) < NUM_CH;
        ch_sel  = chan_f[CH_W-1:0];
        acc     = (ch_wr || ch_rd) && idx_ok;
        sel_val = idx[0] ? cnt_rv[ch_sel] : addr_rv[ch_sel];
        ch_byte = ff_q ? sel_val[15:8] : sel_val[7:0];
    end

    // Shared byte pointer: toggles per channel access, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n)      ff_q <= 1'b0;
        else if (ff_clr) ff_q <= 1'b0;
        else if (acc)    ff_q <= ~ff_q;
    end

    // Registered read data; channel reads take priority over page reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (ch_rd) rdata <= idx_ok ? ch_byte : '0;
        else if (pg_rd) rdata <= pg_byte;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dmar_chan #(.SHIFT(SHIFT)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_wr && idx_ok && chan_f == 3'(i)),
            .wr_cnt   (idx[0]),
            .wr_hi    (ff_q),
            .wdata    (wdata),
            .upd_en   (upd_vld && upd_ch == CH_W'(i)),
            .upd_cnt  (upd_cnt),
            .dec      (mode_dec[i]),
            .addr_rv  (addr_rv[i]),
            .cnt_rv   (cnt_rv[i]),
            .cur_addr (cur_w[i])
        );
        assign phys_addr[i*PHYS_W +: PHYS_W] =
            {pageh_q[i][6:0], page_q[i], 16'h0000} | PHYS_W'(cur_w[i]);
    end

    dmar_page #(.NUM_CH(NUM_CH)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_wr   (pg_wr),
        .pg_hi   (pg_hi),
        .pg_off  (pg_off),
        .wdata   (wdata),
        .slot_ok (pg_ok),
        .rd_byte (pg_byte),
        .page_q  (page_q),
        .pageh_q (pageh_q)
    );

    // R2: every valid access inverts the pointer.
    a_r2_ff_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ff_clr) |=> (ff_q != $past(ff_q)));

    // R9: the clear command leaves the pointer at zero.
    a_r9_ff_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clr |=> !ff_q);

    // R10: a progress update alone never moves the pointer.
    a_r10_update_keeps_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && !ch_wr && !ch_rd && !ff_clr) |=> $stable(ff_q));

    // R6: an out-of-range channel access keeps the pointer.
    a_r6_bad_index_keeps_ff: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_wr || ch_rd) && !idx_ok && !ff_clr) |=> $stable(ff_q));

    // R6: an out-of-range channel read returns zero.
    a_r6_bad_index_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rd && !idx_ok) |=> (rdata == '0));

    // R7: a page read of an unmapped offset returns zero.
    a_r7_bad_page_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_rd && !ch_rd && !pg_ok) |=> (rdata == '0));

endmodule

// File: tb/dma_chan_regs_test.sv
// Scoreboard bench: read tasks push expected bytes, a monitor pops and compares.
module dma_chan_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_off = '0;
    logic        ch_wr = 1'b0, ch_rd = 1'b0;
    logic [2:0]  pg_off = '0;
    logic        pg_hi = 1'b0, pg_wr = 1'b0, pg_rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic        ff_clr = 1'b0;
    logic [3:0]  mode_dec = '0;
    logic        upd_vld = 1'b0;
    logic [1:0]  upd_ch = '0;
    logic [16:0] upd_cnt = '0;
    logic [7:0]  rdata, rdata_w;
    logic [123:0] phys, phys_w;

    int checks = 0;
    int errors = 0;
    logic rd_issued = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs #(.NUM_CH(4), .SHIFT(0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .pg_off(pg_off), .pg_hi(pg_hi), .pg_wr(pg_wr), .pg_rd(pg_rd), .wdata(wdata),
        .ff_clr(ff_clr), .mode_dec(mode_dec), .upd_vld(upd_vld), .upd_ch(upd_ch),
        .upd_cnt(upd_cnt[15:0]), .rdata(rdata), .phys_addr(phys)
    );

    dma_chan_regs #(.NUM_CH(4), .SHIFT(1)) uut_w (
        .clk(clk), .rst_n(rst_n), .reg_off({reg_off, 1'b0}), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .pg_off(pg_off), .pg_hi(pg_hi), .pg_wr(pg_wr), .pg_rd(pg_rd), .wdata(wdata),
        .ff_clr(ff_clr), .mode_dec(mode_dec), .upd_vld(upd_vld), .upd_ch(upd_ch),
        .upd_cnt(upd_cnt), .rdata(rdata_w), .phys_addr(phys_w)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ch_write(input logic [3:0] idx, input logic [7:0] d);
        reg_off = idx; wdata = d; ch_wr = 1'b1;
        @(negedge clk); ch_wr = 1'b0;
    endtask

    task automatic ch_read(input logic [3:0] idx, input logic [7:0] exp, input string tag);
        reg_off = idx; ch_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); ch_rd = 1'b0;
    endtask

    task automatic pg_write(input logic [2:0] off, input logic hi, input logic [7:0] d);
        pg_off = off; pg_hi = hi; wdata = d; pg_wr = 1'b1;
        @(negedge clk); pg_wr = 1'b0;
    endtask

    task automatic pg_read(input logic [2:0] off, input logic hi, input logic [7:0] exp, input string tag);
        pg_off = off; pg_hi = hi; pg_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); pg_rd = 1'b0;
    endtask

    task automatic clear_ff();
        ff_clr = 1'b1;
        @(negedge clk); ff_clr = 1'b0;
    endtask

    task automatic update(input logic [1:0] ch, input logic [16:0] cnt);
        upd_ch = ch; upd_cnt = cnt; upd_vld = 1'b1;
        @(negedge clk); upd_vld = 1'b0;
    endtask

    function automatic logic [30:0] ph(input logic [123:0] v, input int ch);
        return v[ch*31 +: 31];
    endfunction

    // Note which edges carried a read strobe.
    always @(posedge clk) rd_issued <= ch_rd | pg_rd;

    // Monitor: compare each registered read result with the scoreboard head.
    always @(negedge clk) begin
        if (rd_issued) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard empty actual %h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset rdata", {24'h0, rdata}, 32'h0);
        check("R9 reset phys ch1", {1'b0, ph(phys, 1)}, 32'h0);
        ch_read(4'd2, 8'h00, "R9 reset address reads zero");
        clear_ff();

        // R1 R2: byte-wise address load and readback on channel 1
        ch_write(4'd2, 8'h34); ch_write(4'd2, 8'h12);
        ch_read(4'd2, 8'h34, "R1 addr low"); ch_read(4'd2, 8'h12, "R2 addr high");
        ch_write(4'd3, 8'hFF); ch_write(4'd3, 8'h00);
        ch_read(4'd3, 8'hFF, "R1 count low"); ch_read(4'd3, 8'h00, "R1 count high");
        check("R8 phys ch1 address only", {1'b0, ph(phys, 1)}, 32'h0000_1234);
        check("R11 word build doubles address", {1'b0, ph(phys_w, 1)}, 32'h0000_2468);

        // R4 R5 R10: live readback with progress, update between byte reads
        update(2'd1, 17'h10);
        ch_read(4'd2, 8'h44, "R5 addr plus progress low");
        check("R11 word addr low", {24'h0, rdata_w}, 32'h3C);
        update(2'd1, 17'h10);
        ch_read(4'd2, 8'h12, "R10 update kept pointer on high byte");
        check("R11 word addr high", {24'h0, rdata_w}, 32'h12);
        ch_read(4'd3, 8'hEF, "R4 count minus progress low");
        check("R11 word count low", {24'h0, rdata_w}, 32'hF7);
        ch_read(4'd3, 8'h00, "R4 count high");

        // R5: decrement mode
        mode_dec = 4'b0010;
        ch_read(4'd2, 8'h24, "R5 decrement low"); ch_read(4'd2, 8'h12, "R5 decrement high");

        // R2: pointer shared across channels
        ch_write(4'd4, 8'hAA);
        ch_read(4'd2, 8'h12, "R2 shared pointer gives high byte");
        // R9: clear after an access
        ch_read(4'd2, 8'h24, "R2 low after even count");
        clear_ff();
        ch_read(4'd2, 8'h24, "R9 clear returns to low byte");
        clear_ff();

        // R6: out-of-range channel index
        ch_read(4'd8, 8'h00, "R6 bad index reads zero");
        ch_write(4'd9, 8'h55);
        ch_read(4'd2, 8'h24, "R6 bad index left pointer");
        clear_ff();

        // R3: high-byte count write reloads channel 1
        ch_write(4'd3, 8'h00); ch_write(4'd3, 8'h01);
        ch_read(4'd2, 8'h34, "R3 reload addr low"); ch_read(4'd2, 8'h12, "R3 reload addr high");
        ch_read(4'd3, 8'h00, "R3 reload count low"); ch_read(4'd3, 8'h01, "R3 reload count high");
        // R3: low-byte write keeps working state
        update(2'd1, 17'h5);
        ch_write(4'd2, 8'h40);
        clear_ff();
        ch_read(4'd2, 8'h2F, "R3 low write kept progress and address");
        clear_ff();
        check("R3 low write kept phys", {1'b0, ph(phys, 1)}, 32'h0000_1234);

        // R8 R7: page bytes of channel 1
        pg_write(3'd3, 1'b0, 8'h56); pg_write(3'd3, 1'b1, 8'hFF);
        check("R8 phys ch1 with pages", {1'b0, ph(phys, 1)}, 32'h7F56_1234);
        pg_read(3'd3, 1'b0, 8'h56, "R7 page read"); pg_read(3'd3, 1'b1, 8'hFF, "R7 high page read");

        // R7: page port map and ignored offsets
        pg_write(3'd7, 1'b0, 8'h11); pg_write(3'd1, 1'b0, 8'h22); pg_write(3'd2, 1'b0, 8'h33);
        check("R7 offset 7 to ch0", {1'b0, ph(phys, 0)}, 32'h0011_0000);
        check("R7 offset 1 to ch2", {1'b0, ph(phys, 2)}, 32'h0022_0000);
        check("R7 offset 2 to ch3", {1'b0, ph(phys, 3)}, 32'h0033_0000);
        pg_write(3'd0, 1'b0, 8'h99); pg_write(3'd5, 1'b1, 8'h77);
        pg_read(3'd0, 1'b0, 8'h00, "R7 offset 0 reads zero");
        pg_read(3'd5, 1'b1, 8'h00, "R7 offset 5 reads zero");
        check("R7 bad offset left ch0", {1'b0, ph(phys, 0)}, 32'h0011_0000);
        check("R7 bad offset left ch1", {1'b0, ph(phys, 1)}, 32'h7F56_1234);
        check("R7 bad offset left ch3", {1'b0, ph(phys, 3)}, 32'h0033_0000);
        pg_read(3'd7, 1'b0, 8'h11, "R7 offset 7 readback");

        // R10: same-cycle high write and update, reload wins
        ch_write(4'd2, 8'h00);
        reg_off = 4'd2; wdata = 8'h12; ch_wr = 1'b1;
        upd_ch = 2'd1; upd_cnt = 17'h30; upd_vld = 1'b1;
        @(negedge clk); ch_wr = 1'b0; upd_vld = 1'b0;
        ch_read(4'd2, 8'h00, "R10 reload beat update low");
        ch_read(4'd2, 8'h12, "R10 reload beat update high");
        check("R10 phys after collision", {1'b0, ph(phys, 1)}, 32'h7F56_1200);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule